// File: doc/BRIEF.md
# Head stepper and track tracker

This block moves the read/write head of a floppy drive one track at a time and keeps a track register that follows the head. It accepts four commands: step one track inward, step one track outward, seek to a given track, and return to track zero. For each single-track move it raises a step pulse with a direction level. It adds to or takes from the track register on every pulse, according to the direction. A seek ends when the register equals the target. A return to zero ends when the track-zero sensor reports the head over track 0, and the register is then cleared.

Pulses are spaced by a programmable interval. One of four rates is chosen with each command. While a read or write is in progress, a separate output tells the drive that the head sits in the high-numbered zone of tracks 44 to 76.

Top module: `head_step_ctrl`

## Requirements
- R1: Each single-track move produces exactly one step pulse, high for PULSE_W (default 4) clocks, and the step output is high only while the block is busy.
- R2: The direction output is 1 for an inward move and 0 for an outward move. It takes its value at least one clock before the step output rises and holds it until the step output falls.
- R3: The track register changes only at the end of a pulse or on a return-to-zero clear. It rises by one after an inward pulse and falls by one after an outward pulse, and an outward pulse at 0 leaves it at 0. The new value is visible in the first clock in which the step output is low again.
- R4: Command code 2 (seek) steps toward cmd_target until the track register equals it, and emits no pulse when they are already equal.
- R5: Command code 3 (return to zero) steps outward until trk0 is 1 at a decision point, then loads 0 into the track register.
- R6: Within one command the step output stays low for exactly (BASE_GAP << rate) + 2 clocks between pulses, where rate is rate_sel sampled when the command is accepted. BASE_GAP defaults to 8.
- R7: high_trk is 1 exactly when rw_active is 1 and the track register lies from ZONE_LO (44) to ZONE_HI (76) inclusive.
- R8: cmd_valid is accepted when busy is 0. Code 0 steps in and code 1 steps out. busy is 1 from the clock after acceptance, and done is a one-clock pulse in the first clock in which busy is 0 again.
- R9: A command offered while busy is 1 is ignored and changes neither the step sequence nor the track register.
- R10: After reset, step_out, dir_out, done and busy are 0 and the track register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered this clock |
| cmd_op | input | 2 | 0 step in, 1 step out, 2 seek, 3 return to zero |
| cmd_target | input | TW | Seek target track |
| rate_sel | input | 2 | Step interval selector, sampled with the command |
| trk0 | input | 1 | Head over track 0 sensor |
| rw_active | input | 1 | A read or write is in progress |
| step_out | output | 1 | Step pulse |
| dir_out | output | 1 | 1 inward, 0 outward |
| track_q | output | TW | Track register |
| done | output | 1 | Command finished (one clock) |
| busy | output | 1 | Command in progress |
| high_trk | output | 1 | Head in high zone during read/write |

## Verification
Two things can fall on the same clock edge. One is the done pulse of a finished command, and the other is acceptance of the next command. The bench raises each new cmd_valid in the very cycle done is seen, so the block must return to idle and take the new command back to back. A behavioural model follows every clock and checks that no pulse, track value or done pulse is lost or repeated. A stray command is also dropped into the middle of a long seek, and the model confirms the sequence continues untouched.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    OP_IN   = 2'd0,
    OP_OUT  = 2'd1,
    OP_SEEK = 2'd2,
    OP_HOME = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_DECIDE = 3'd1,
    S_SETUP  = 3'd2,
    S_PULSE  = 3'd3,
    S_GAP    = 3'd4
  } state_e;

  // interval between pulses for a given rate code
  function automatic int unsigned gap_len(int unsigned base, logic [1:0] rate);
    return base << rate;
  endfunction

endpackage

// File: rtl/hs_track_reg.sv
module hs_track_reg #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          adv_in,
  input  logic          clr,
  output logic [TW-1:0] trk
);

  // next value after one emitted pulse; outward stops at zero
  function automatic logic [TW-1:0] track_after(logic [TW-1:0] cur, logic inward);
    if (inward)
      return cur + TW'(1);
    else if (cur == '0)
      return '0;
    else
      return cur - TW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      trk <= '0;
    else if (clr)
      trk <= '0;
    else if (adv)
      trk <= track_after(trk, adv_in);
  end

endmodule

// File: rtl/hs_zone.sv
module hs_zone #(
  parameter int TW      = 8,
  parameter int ZONE_LO = 44,
  parameter int ZONE_HI = 76
) (
  input  logic [TW-1:0] trk,
  input  logic          rw_active,
  output logic          high_trk
);

  localparam int TOP_VAL = (1 << TW) - 1;

  logic above_lo;
  logic below_hi;

  assign above_lo = (int'(trk) >= ZONE_LO);

  generate
    if (ZONE_HI >= TOP_VAL) begin : g_open_top
      assign below_hi = 1'b1;
    end else begin : g_bounded
      assign below_hi = (int'(trk) <= ZONE_HI);
    end
  endgenerate

  assign high_trk = rw_active & above_lo & below_hi;

endmodule

// File: rtl/hs_seq.sv
module hs_seq
  import hs_pkg::*;
#(
  parameter int TW       = 8,
  parameter int PULSE_W  = 4,
  parameter int BASE_GAP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [TW-1:0] cmd_target,
  input  logic [1:0]    rate_sel,
  input  logic [TW-1:0] trk,
  input  logic          trk0,
  output logic          step_out,
  output logic          dir_out,
  output logic          busy,
  output logic          done,
  output logic          adv,
  output logic          clr
);

  localparam int MAX_GAP = BASE_GAP << 3;
  localparam int CNT_MAX = (PULSE_W > MAX_GAP) ? PULSE_W : MAX_GAP;
  localparam int CW      = $clog2(CNT_MAX + 1);

  state_e        state;
  op_e           op_q;
  logic [TW-1:0] tgt_q;
  logic [1:0]    rate_q;
  logic [CW-1:0] cnt;
  logic          moved;
  logic          dir_q;
  logic          done_q;
  logic          need_step;
  logic          want_in;

  always_comb begin
    need_step = 1'b0;
    want_in   = 1'b0;
    unique case (op_q)
      OP_IN:   begin need_step = !moved;        want_in = 1'b1; end
      OP_OUT:  begin need_step = !moved;        want_in = 1'b0; end
      OP_SEEK: begin need_step = (trk != tgt_q); want_in = (tgt_q > trk); end
      OP_HOME: begin need_step = !trk0;         want_in = 1'b0; end
      default: begin need_step = 1'b0;          want_in = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= OP_IN;
      tgt_q  <= '0;
      rate_q <= '0;
      cnt    <= '0;
      moved  <= 1'b0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            op_q   <= op_e'(cmd_op);
            tgt_q  <= cmd_target;
            rate_q <= rate_sel;
            moved  <= 1'b0;
            state  <= S_DECIDE;
          end
        end
        S_DECIDE: begin
          if (need_step) begin
            dir_q <= want_in;
            state <= S_SETUP;
          end else begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
        S_SETUP: begin
          cnt   <= CW'(PULSE_W - 1);
          state <= S_PULSE;
        end
        S_PULSE: begin
          if (cnt == '0) begin
            cnt   <= CW'(gap_len(BASE_GAP, rate_q) - 1);
            moved <= 1'b1;
            state <= S_GAP;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        S_GAP: begin
          if (cnt == '0)
            state <= S_DECIDE;
          else
            cnt <= cnt - CW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign step_out = (state == S_PULSE);
  assign dir_out  = dir_q;
  assign busy     = (state != S_IDLE);
  assign done     = done_q;
  assign adv      = (state == S_PULSE) && (cnt == '0);
  assign clr      = (state == S_DECIDE) && (op_q == OP_HOME) && trk0;

endmodule

// File: rtl/head_step_ctrl.sv
module head_step_ctrl
  import hs_pkg::*;
#(
  parameter int TW       = 8,
  parameter int PULSE_W  = 4,
  parameter int BASE_GAP = 8,
  parameter int ZONE_LO  = 44,
  parameter int ZONE_HI  = 76
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [TW-1:0] cmd_target,
  input  logic [1:0]    rate_sel,
  input  logic          trk0,
  input  logic          rw_active,
  output logic          step_out,
  output logic          dir_out,
  output logic [TW-1:0] track_q,
  output logic          done,
  output logic          busy,
  output logic          high_trk
);

  // internal events, named for the checker
  logic trk_adv;
  logic trk_clr;

  hs_seq #(
    .TW(TW), .PULSE_W(PULSE_W), .BASE_GAP(BASE_GAP)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_target(cmd_target),
    .rate_sel(rate_sel), .trk(track_q), .trk0(trk0),
    .step_out(step_out), .dir_out(dir_out), .busy(busy), .done(done),
    .adv(trk_adv), .clr(trk_clr)
  );

  hs_track_reg #(.TW(TW)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .adv(trk_adv), .adv_in(dir_out), .clr(trk_clr), .trk(track_q)
  );

  hs_zone #(.TW(TW), .ZONE_LO(ZONE_LO), .ZONE_HI(ZONE_HI)) u_zone (
    .trk(track_q), .rw_active(rw_active), .high_trk(high_trk)
  );

endmodule

// File: rtl/head_step_ctrl_chk.sv
module head_step_ctrl_chk #(
  parameter int TW      = 8,
  parameter int ZONE_LO = 44,
  parameter int ZONE_HI = 76
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step_out,
  input logic          dir_out,
  input logic [TW-1:0] track_q,
  input logic          done,
  input logic          busy,
  input logic          high_trk,
  input logic          rw_active,
  input logic          trk_adv,
  input logic          trk_clr
);

  AST_STEP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    step_out |-> busy); // R1

  AST_ADV_ENDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trk_adv |=> !step_out); // R1

  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    step_out |-> $stable(dir_out)); // R2

  AST_TRACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!trk_adv && !trk_clr) |=> $stable(track_q)); // R3

  AST_TRACK_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_adv && !trk_clr && dir_out && track_q != '1) |=> track_q == $past(track_q) + TW'(1)); // R3

  AST_TRACK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_adv && !trk_clr && !dir_out && track_q != '0) |=> track_q == $past(track_q) - TW'(1)); // R3

  AST_HOME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    trk_clr |=> track_q == '0); // R5

  AST_ZONE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !rw_active |-> !high_trk); // R7

  AST_ZONE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    high_trk |-> (int'(track_q) >= ZONE_LO && int'(track_q) <= ZONE_HI)); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

endmodule

bind head_step_ctrl head_step_ctrl_chk #(
  .TW(TW), .ZONE_LO(ZONE_LO), .ZONE_HI(ZONE_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .step_out(step_out), .dir_out(dir_out),
  .track_q(track_q), .done(done), .busy(busy), .high_trk(high_trk),
  .rw_active(rw_active), .trk_adv(trk_adv), .trk_clr(trk_clr)
);

// File: tb/head_step_ctrl_tb_top.sv
`timescale 1ns/100ps
module head_step_ctrl_tb_top;

  localparam int PW = 4;
  localparam int BG = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_target = 8'd0;
  logic [1:0] rate_sel = 2'd0;
  logic       trk0 = 1'b0;
  logic       rw_active = 1'b0;
  logic       step_out, dir_out, done, busy, high_trk;
  logic [7:0] track_q;

  always #2.5 clk = ~clk;

  head_step_ctrl #(.TW(8), .PULSE_W(PW), .BASE_GAP(BG), .ZONE_LO(44), .ZONE_HI(76)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_target(cmd_target), .rate_sel(rate_sel), .trk0(trk0), .rw_active(rw_active),
    .step_out(step_out), .dir_out(dir_out), .track_q(track_q), .done(done),
    .busy(busy), .high_trk(high_trk)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int head_pos = 5;          // physical head, unknown to the controller at reset
  int m_phase = 0;           // 0 idle, 1 choose, 2 lead-in, 3 pulse, 4 spacing
  int m_left = 0;
  int m_op = 0, m_tgt = 0, m_rate = 0;
  bit m_moved = 0, m_dir = 0, m_done = 0;
  int m_trk = 0;
  bit model_on = 0;

  always @(posedge clk) begin
    #1;
    if (model_on) begin
      bit need, wdir, fin, moved_now;
      need = 0; wdir = 0; fin = 0; moved_now = 0;
      case (m_phase)
        0: if (cmd_valid) begin
             m_op = int'(cmd_op); m_tgt = int'(cmd_target); m_rate = int'(rate_sel);
             m_moved = 0; m_phase = 1;
           end
        1: begin
             if (m_op == 0)      begin need = !m_moved; wdir = 1; end
             else if (m_op == 1) begin need = !m_moved; wdir = 0; end
             else if (m_op == 2) begin need = (m_trk != m_tgt); wdir = (m_tgt > m_trk); end
             else                begin need = !trk0; wdir = 0; end
             if (need) begin m_dir = wdir; m_phase = 2; end
             else begin
               fin = 1; m_phase = 0;
               if (m_op == 3) m_trk = 0;
             end
           end
        2: begin m_phase = 3; m_left = PW; end
        3: begin
             m_left--;
             if (m_left == 0) begin
               moved_now = 1; m_moved = 1; m_phase = 4; m_left = BG << m_rate;
             end
           end
        default: begin
             m_left--;
             if (m_left == 0) m_phase = 1;
           end
      endcase
      if (moved_now) begin
        if (m_dir) begin m_trk = (m_trk + 1) % 256; head_pos++; end
        else begin
          if (m_trk > 0) m_trk--;
          if (head_pos > 0) head_pos--;
        end
      end
      m_done = fin;
      chk(step_out == (m_phase == 3), "R1 step", int'(step_out), int'(m_phase == 3));
      chk(dir_out == m_dir, "R2 dir", int'(dir_out), int'(m_dir));
      chk(int'(track_q) == m_trk, "R3 track", int'(track_q), m_trk);
      chk(busy == (m_phase != 0), "R8 busy", int'(busy), int'(m_phase != 0));
      chk(done == m_done, "R8 done", int'(done), int'(m_done));
      chk(high_trk == (rw_active && m_trk >= 44 && m_trk <= 76), "R7 zone",
          int'(high_trk), int'(rw_active && m_trk >= 44 && m_trk <= 76));
    end
    trk0 = (head_pos == 0);
  end

  // ---------------- pulse shape monitor ----------------
  int rises = 0;
  int hi_len = 0, lo_len = 0;
  bit lo_valid = 0, prev_step = 0, prev_dir = 0;
  int cur_rate = 0;

  always @(posedge clk) begin
    #1;
    if (model_on) begin
      if (step_out && !prev_step) begin
        rises++;
        chk(dir_out == prev_dir, "R2 dir before rise", int'(dir_out), int'(prev_dir));
        if (lo_valid) chk(lo_len == (BG << cur_rate) + 2, "R6 spacing", lo_len, (BG << cur_rate) + 2);
        hi_len = 1; lo_valid = 0;
      end else if (step_out) begin
        hi_len++;
      end else if (prev_step) begin
        chk(hi_len == PW, "R1 width", hi_len, PW);
        lo_len = 1; lo_valid = 1;
      end else begin
        lo_len++;
      end
      if (!busy) lo_valid = 0;
    end
    prev_step = step_out;
    prev_dir  = dir_out;
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input int op, input int tgt, input int rate);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_target = 8'(tgt); rate_sel = 2'(rate);
    cur_rate = rate;
    @(negedge clk);
    cmd_valid = 1'b0;
    rate_sel = 2'(3 - rate);   // later changes must not matter (R6)
  endtask

  task automatic wait_done;
    do begin @(posedge clk); #2; end while (!done);
  endtask

  task automatic run(input int op, input int tgt, input int rate,
                     input int exp_pulses, input int exp_trk, input string req);
    int r0;
    r0 = rises;
    issue(op, tgt, rate);
    wait_done();
    chk(rises - r0 == exp_pulses, {req, " pulse count"}, rises - r0, exp_pulses);
    chk(int'(track_q) == exp_trk, {req, " final track"}, int'(track_q), exp_trk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(step_out == 0, "R10 step", int'(step_out), 0);
    chk(dir_out == 0, "R10 dir", int'(dir_out), 0);
    chk(track_q == 0, "R10 track", int'(track_q), 0);
    chk(done == 0 && busy == 0, "R10 done/busy", int'(done) + int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    model_on = 1;

    run(3, 0, 0, 5, 0, "R5 restore from 5");
    run(0, 0, 0, 1, 1, "R1 R8 step in");
    rw_active = 1'b1;
    run(2, 50, 1, 49, 50, "R4 seek up");
    chk(high_trk == 1, "R7 in zone", int'(high_trk), 1);
    run(1, 0, 2, 1, 49, "R8 step out");
    run(2, 49, 0, 0, 49, "R4 seek equal");

    // R9: stray command during a long seek
    begin
      int r0;
      r0 = rises;
      issue(2, 80, 3);
      repeat (40) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd3; cmd_target = 8'd0;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_done();
      chk(rises - r0 == 31, "R9 ignored pulse count", rises - r0, 31);
      chk(int'(track_q) == 80, "R9 ignored track", int'(track_q), 80);
      chk(high_trk == 0, "R7 above zone", int'(high_trk), 0);
    end

    rw_active = 1'b0;
    run(2, 60, 1, 20, 60, "R4 seek down");
    chk(high_trk == 0, "R7 gated by rw", int'(high_trk), 0);
    run(3, 0, 0, 60, 0, "R5 restore from 60");
    run(1, 0, 0, 1, 0, "R3 step out at zero");
    run(2, 0, 2, 0, 0, "R4 seek zero at zero");

    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule